// File: doc/BRIEF.md
# Control-Gated Block Admission Gate

This block sits ahead of a block-oriented streaming engine. It lets input samples through one block at a time. Before any sample of a block goes out, a control word for that block must be waiting. The control word carries the block length and a direction bit. Each block uses up exactly one control word, even when its settings match those of the previous block.

Control words and samples each pass through a 16-entry queue. The downstream side sees one sample stream. Each sample carries a last flag, which the gate derives by counting against the block length in the control word. Each sample also carries the direction bit of its block.

After reset the gate holds its output for a fixed number of cycles. Samples that arrive during that window pile up in the sample queue.

All three streams follow a valid/ready handshake. A word moves on a cycle only when valid and ready are both high. Neither input ready depends on the same cycle's valid.

Back-pressure on the output is a build-time option, selected by the `BACKPRESSURE` parameter:
- **Enabled:** a low `m_ready` freezes the output word. The sample queue then fills, and `s_dat_ready` eventually drops.
- **Disabled:** `m_ready` is ignored, and a sample leaves on every cycle one is available.

A sticky flag reports any input last flag that disagrees with the counted block length. The sample concerned is still forwarded.

Top module: `blk_admit_gate`

## Requirements
- R1: A word enters a queue only on a cycle where its valid and ready are both high, and each accepted sample leaves exactly once, in arrival order, on `m_data`.
- R2: The control queue holds 16 words. `s_ctrl_ready` is low only when 16 accepted words have not yet been consumed by a block, or before the first clock edge after reset release.
- R3: The sample queue holds 16 samples. `s_dat_ready` is low during reset, rises one clock edge after reset release, and afterwards is low only while 16 accepted samples wait.
- R4: `m_valid` stays low for the first 44 clock edges after reset release. With data and a control word waiting, it rises right after the 44th edge.
- R5: No sample is released at the start of a block unless a control word is queued. Each block consumes one control word at its first sample. When a block ends with no control word queued, `m_valid` stays low and samples collect in the sample queue.
- R6: A control word's bits [3:0] hold log2 of the block length, with values below 3 treated as 3 and values above 12 treated as 12. `m_last` is high on exactly the final sample of each block and ignores the input last flag.
- R7: `m_dir` equals bit 4 of the control word of the block being sent, and does not change within a block.
- R8: When control words arrive no later than each block's first sample and samples arrive every cycle, consecutive blocks leave back to back with no idle output cycle.
- R9: With back-pressure enabled, while `m_valid` is high and `m_ready` is low, `m_data`, `m_last` and `m_dir` hold their values and `m_valid` stays high.
- R10: With back-pressure enabled, holding `m_ready` low while samples keep arriving fills the sample queue and drives `s_dat_ready` low.
- R11: `len_err` is set, and stays set until reset, when a released sample's input last flag differs from its counted `m_last`. That sample is still forwarded.
- R12: During reset both input readies, `m_valid` and `len_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_ctrl_valid | input | 1 | Control word valid |
| s_ctrl_ready | output | 1 | Control queue can accept |
| s_ctrl_word | input | 5 | Bit 4 direction, bits [3:0] log2 block length |
| s_dat_valid | input | 1 | Input sample valid |
| s_dat_ready | output | 1 | Sample queue can accept |
| s_dat_data | input | DATA_W | Input sample |
| s_dat_last | input | 1 | Sender's end-of-block mark (checked only) |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts (ignored if back-pressure disabled) |
| m_data | output | DATA_W | Output sample |
| m_last | output | 1 | Final sample of the block |
| m_dir | output | 1 | Direction bit of the current block |
| len_err | output | 1 | Sticky length mismatch flag |

## Verification
The hardest state to reach from the ports is control starvation at a block boundary. The sample queue must be full, while the output sits idle, waiting for a control word. The stimulus gets there by capping how many control words the sender may issue. The sender then lets that many blocks drain and keeps offering samples until `s_dat_ready` falls. Only after that is the cap lifted.

A second hard case is a full control queue. It is reached by stopping samples while control words keep coming. Long blocks with clamped lengths, and a single deliberately flipped input last flag, cover the clamping rule and the sticky error flag. A behavioural queue model checks every output on every cycle.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  localparam int LOG_W  = 4;
  localparam int CTRL_W = LOG_W + 1;

  typedef struct packed {
    logic             dir;
    logic [LOG_W-1:0] log2n;
  } ctrl_word_t;
endpackage

// File: rtl/blk_admit_fifo.sv
module blk_admit_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R1: writes only land in free space
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: a block never draws from an empty queue
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/blk_admit_init.sv
module blk_admit_init #(
  parameter int HOLD = 44
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold,
  output logic awake
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (cnt != CW'(HOLD)) cnt <= cnt + CW'(1);
  end

  assign hold  = (cnt != CW'(HOLD));
  assign awake = (cnt != '0);

  // R4: once released, the hold-off never returns
  p_hold_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> !hold);
endmodule

// File: rtl/blk_admit_seq.sv
module blk_admit_seq
  import blk_admit_pkg::*;
#(
  parameter int MIN_LOG      = 3,
  parameter int MAX_LOG      = 12,
  parameter bit BACKPRESSURE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_word_t ctrl_head,
  input  logic       ctrl_empty,
  input  logic       dat_last_in,
  input  logic       dat_empty,
  input  logic       hold,
  input  logic       m_ready,
  output logic       ctrl_pop,
  output logic       dat_pop,
  output logic       m_valid,
  output logic       m_last,
  output logic       m_dir,
  output logic       len_err
);
  localparam int LEN_W = MAX_LOG + 1;

  logic             active;
  logic [LEN_W-1:0] rem;
  logic             dir_q;
  logic             err_q;
  logic [LOG_W-1:0] eff_log;
  logic [LEN_W-1:0] head_len;
  logic             take;
  logic             fire;

  always_comb begin
    if (ctrl_head.log2n < LOG_W'(MIN_LOG))      eff_log = LOG_W'(MIN_LOG);
    else if (ctrl_head.log2n > LOG_W'(MAX_LOG)) eff_log = LOG_W'(MAX_LOG);
    else                                        eff_log = ctrl_head.log2n;
    head_len = LEN_W'(1) << eff_log;
  end

  generate
    if (BACKPRESSURE) begin : g_bp
      assign take = m_ready;
    end else begin : g_nobp
      assign take = 1'b1;
    end
  endgenerate

  assign m_valid  = !hold && !dat_empty && (active || !ctrl_empty);
  assign m_last   = active ? (rem == LEN_W'(1)) : (head_len == LEN_W'(1));
  assign m_dir    = active ? dir_q : ctrl_head.dir;
  assign fire     = m_valid && take;
  assign dat_pop  = fire;
  assign ctrl_pop = fire && !active;
  assign len_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem    <= '0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (fire) begin
      if (!active) begin
        dir_q <= ctrl_head.dir;
        if (!m_last) begin
          active <= 1'b1;
          rem    <= head_len - LEN_W'(1);
        end
      end else begin
        rem <= rem - LEN_W'(1);
        if (m_last) active <= 1'b0;
      end
      if (dat_last_in != m_last) err_q <= 1'b1;
    end
  end

  // R11: the mismatch flag is sticky
  p_sticky_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);
  // R7: direction holds between samples of one block
  p_dir_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !m_last) |=> $stable(m_dir));
  // R5: the sample after a block end opens a new block with its own control word
  p_fresh_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_pop && m_last) |=> (!dat_pop || ctrl_pop));

  generate
    if (BACKPRESSURE) begin : g_bp_chk
      // R9: a stalled output word holds its flags
      p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_last) && $stable(m_dir)));
    end
  endgenerate
endmodule

// File: rtl/blk_admit_gate.sv
module blk_admit_gate
  import blk_admit_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CTRL_DEPTH   = 16,
  parameter int DAT_DEPTH    = 16,
  parameter int INIT_HOLD    = 44,
  parameter int MIN_LOG      = 3,
  parameter int MAX_LOG      = 12,
  parameter bit BACKPRESSURE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_ctrl_valid,
  output logic              s_ctrl_ready,
  input  logic [CTRL_W-1:0] s_ctrl_word,
  input  logic              s_dat_valid,
  output logic              s_dat_ready,
  input  logic [DATA_W-1:0] s_dat_data,
  input  logic              s_dat_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              m_dir,
  output logic              len_err
);
  localparam int DW = DATA_W + 1;

  logic              hold, awake;
  logic              ctrl_full, ctrl_empty, ctrl_pop, ctrl_push;
  logic              dat_full, dat_empty, dat_pop, dat_push;
  logic [CTRL_W-1:0] ctrl_raw;
  logic [DW-1:0]     dat_head;
  ctrl_word_t        ctrl_head;

  assign s_ctrl_ready = awake && !ctrl_full;
  assign s_dat_ready  = awake && !dat_full;
  assign ctrl_push    = s_ctrl_valid && s_ctrl_ready;
  assign dat_push     = s_dat_valid && s_dat_ready;
  assign ctrl_head    = ctrl_word_t'(ctrl_raw);
  assign m_data       = dat_head[DATA_W-1:0];

  blk_admit_init #(.HOLD(INIT_HOLD)) u_init (
    .clk(clk), .rst_n(rst_n), .hold(hold), .awake(awake)
  );

  blk_admit_fifo #(.WIDTH(CTRL_W), .DEPTH(CTRL_DEPTH)) u_ctrl_q (
    .clk(clk), .rst_n(rst_n), .push(ctrl_push), .din(s_ctrl_word),
    .pop(ctrl_pop), .dout(ctrl_raw), .full(ctrl_full), .empty(ctrl_empty)
  );

  blk_admit_fifo #(.WIDTH(DW), .DEPTH(DAT_DEPTH)) u_dat_q (
    .clk(clk), .rst_n(rst_n), .push(dat_push), .din({s_dat_last, s_dat_data}),
    .pop(dat_pop), .dout(dat_head), .full(dat_full), .empty(dat_empty)
  );

  blk_admit_seq #(
    .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .BACKPRESSURE(BACKPRESSURE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_head(ctrl_head), .ctrl_empty(ctrl_empty),
    .dat_last_in(dat_head[DATA_W]), .dat_empty(dat_empty), .hold(hold),
    .m_ready(m_ready), .ctrl_pop(ctrl_pop), .dat_pop(dat_pop),
    .m_valid(m_valid), .m_last(m_last), .m_dir(m_dir), .len_err(len_err)
  );

  // R4: nothing leaves during the hold-off window
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !m_valid);

  generate
    if (BACKPRESSURE) begin : g_bp_chk
      // R9: a stalled sample is not replaced
      p_stall_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> $stable(m_data));
    end
  endgenerate
endmodule

// File: tb/blk_admit_gate_tb.sv
module blk_admit_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK       = 48;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_ctrl_valid = 1'b0;
  logic        s_ctrl_ready;
  logic [4:0]  s_ctrl_word = '0;
  logic        s_dat_valid = 1'b0;
  logic        s_dat_ready;
  logic [15:0] s_dat_data = '0;
  logic        s_dat_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data;
  logic        m_last;
  logic        m_dir;
  logic        len_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_admit_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_ctrl_valid(s_ctrl_valid), .s_ctrl_ready(s_ctrl_ready), .s_ctrl_word(s_ctrl_word),
    .s_dat_valid(s_dat_valid), .s_dat_ready(s_dat_ready), .s_dat_data(s_dat_data),
    .s_dat_last(s_dat_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .m_dir(m_dir), .len_err(len_err)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // stimulus plan
  int plan_log [NBLK];
  bit plan_dir [NBLK];
  int ctrl_idx = 0, ctrl_limit = NBLK;
  int dblk = 0, dpos = 0;
  int dval = 0;
  bit corrupt = 0;
  int ctrl_mode = 0, dat_mode = 0, rdy_mode = 1;

  function automatic int len_of(input int lg);
    int e;
    e = (lg < 3) ? 3 : ((lg > 12) ? 12 : lg);
    return 1 << e;
  endfunction

  // reference model state
  logic [4:0]  cq [$];
  logic [16:0] dq [$];
  bit mact = 0;
  int mrem = 0;
  bit mdir = 0;
  bit merr = 0;
  int mcnt = 0;
  int ecnt = 0;

  function automatic bit e_cready();
    return (mcnt > 0) && (cq.size() < 16);
  endfunction
  function automatic bit e_dready();
    return (mcnt > 0) && (dq.size() < 16);
  endfunction
  function automatic bit e_mvalid();
    return (mcnt >= 44) && (dq.size() > 0) && (mact || cq.size() > 0);
  endfunction
  function automatic bit e_mlast();
    if (mact) return mrem == 1;
    return len_of(int'(cq[0][3:0])) == 1;
  endfunction
  function automatic bit e_mdir();
    return mact ? mdir : cq[0][4];
  endfunction

  // model update and sender bookkeeping
  always @(posedge clk) begin
    if (!rst_n) begin
      cq.delete(); dq.delete();
      mact = 0; mrem = 0; mdir = 0; merr = 0; mcnt = 0; ecnt = 0;
    end else begin
      bit cf, df, of, el;
      logic [16:0] h;
      logic [4:0] cw;
      cf = s_ctrl_valid && e_cready();
      df = s_dat_valid && e_dready();
      of = e_mvalid() && m_ready;
      el = of ? e_mlast() : 1'b0;
      if (of) begin
        h = dq.pop_front();
        if (h[16] != el) merr = 1;
        if (!mact) begin
          cw = cq.pop_front();
          mdir = cw[4];
          if (!el) begin mact = 1; mrem = len_of(int'(cw[3:0])) - 1; end
        end else begin
          mrem--;
          if (el) mact = 0;
        end
      end
      if (cf) begin cq.push_back(s_ctrl_word); ctrl_idx++; end
      if (df) begin
        dq.push_back({s_dat_last, s_dat_data});
        dval++;
        corrupt = 0;
        dpos++;
        if (dpos == len_of(plan_log[dblk])) begin dpos = 0; dblk++; end
      end
      if (mcnt < 44) mcnt++;
      ecnt++;
    end
  end

  // sender drive
  always @(negedge clk) begin
    bit cen, den;
    cen = (ctrl_mode == 1) || (ctrl_mode == 2 && $urandom_range(0, 1) == 1);
    den = (dat_mode == 1) || (dat_mode == 2 && $urandom_range(0, 1) == 1);
    s_ctrl_valid <= cen && (ctrl_idx < ctrl_limit) && (ctrl_idx < NBLK);
    s_ctrl_word  <= (ctrl_idx < NBLK) ? {plan_dir[ctrl_idx], 4'(plan_log[ctrl_idx])} : 5'd0;
    s_dat_valid  <= den && (dblk < NBLK);
    s_dat_data   <= 16'(dval * 7 + 3);
    s_dat_last   <= ((dblk < NBLK) && (dpos == len_of(plan_log[dblk]) - 1)) ^ corrupt;
    m_ready      <= (rdy_mode == 1) || (rdy_mode == 2 && $urandom_range(0, 3) != 0);
  end

  // per-cycle comparison against the model
  int first_v = -1;
  int idle_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(s_ctrl_ready === e_cready(), "R2 s_ctrl_ready", int'(s_ctrl_ready), int'(e_cready()));
      chk(s_dat_ready === e_dready(), "R3 s_dat_ready", int'(s_dat_ready), int'(e_dready()));
      chk(m_valid === e_mvalid(), "R5 m_valid", int'(m_valid), int'(e_mvalid()));
      chk(len_err === merr, "R11 len_err", int'(len_err), int'(merr));
      if (e_mvalid()) begin
        chk(m_data === dq[0][15:0], "R1 m_data", int'(m_data), int'(dq[0][15:0]));
        chk(m_last === e_mlast(), "R6 m_last", int'(m_last), int'(e_mlast()));
        chk(m_dir === e_mdir(), "R7 m_dir", int'(m_dir), int'(e_mdir()));
      end
      if (m_valid === 1'b1 && first_v < 0) first_v = ecnt;
      if (ecnt >= 50 && ecnt <= 200 && m_valid !== 1'b1) idle_b++;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", wd, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBLK; i++) begin
      plan_log[i] = 3 + (i % 3);
      plan_dir[i] = ((i * 7) % 3) == 0;
    end
    plan_log[40] = 0;
    plan_log[41] = 15;
    plan_log[42] = 12;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(s_ctrl_ready === 1'b0 && s_dat_ready === 1'b0, "R12 readies in reset",
        int'({s_ctrl_ready, s_dat_ready}), 0);
    chk(m_valid === 1'b0 && len_err === 1'b0, "R12 outputs in reset",
        int'({m_valid, len_err}), 0);

    // admission during hold-off, then back-to-back blocks
    ctrl_limit = 10; ctrl_mode = 1; dat_mode = 1; rdy_mode = 1;
    rst_n = 1'b1;
    repeat (210) @(negedge clk);
    chk(first_v == 44, "R4 first output edge", first_v, 44);
    chk(idle_b == 0, "R8 idle cycles in continuous run", idle_b, 0);

    // starvation: control words withheld
    repeat (60) @(negedge clk);
    chk(m_valid === 1'b0, "R5 idle without control word", int'(m_valid), 0);
    chk(s_dat_ready === 1'b0, "R5 samples held while starved", int'(s_dat_ready), 0);

    // resume, then hold output ready low
    ctrl_limit = NBLK;
    repeat (5) @(negedge clk);
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    begin
      logic [15:0] cap;
      bit steady;
      cap = m_data;
      steady = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (m_valid !== 1'b1 || m_data !== cap) steady = 0;
      end
      chk(steady, "R9 stalled word steady", int'(steady), 1);
    end
    chk(s_dat_ready === 1'b0, "R10 input ready under stall", int'(s_dat_ready), 0);

    // random mix
    rdy_mode = 2; ctrl_mode = 2; dat_mode = 2;
    repeat (400) @(negedge clk);

    // control queue fills when samples stop
    dat_mode = 0; ctrl_mode = 1; rdy_mode = 1;
    repeat (60) @(negedge clk);
    chk(s_ctrl_ready === 1'b0, "R2 control queue full", int'(s_ctrl_ready), 0);

    // run out the plan with one flipped last flag
    chk(len_err === 1'b0, "R11 no error before mismatch", int'(len_err), 0);
    dat_mode = 1;
    repeat (3) @(negedge clk);
    corrupt = 1;
    for (int k = 0; k < 20000 && dblk < NBLK; k++) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(len_err === 1'b1, "R11 sticky error after mismatch", int'(len_err), 1);
    chk(dblk == NBLK, "R6 all planned samples sent", dblk, NBLK);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule